// File: doc/BRIEF.md
# Partial Store Lane Merger

This block turns one unaligned partial store (the "left" or "right" half of a misaligned register store) into a single aligned memory write. A request carries a register value, a byte address, a side select (left or right) and an endianness flag. The unit works out which byte lanes of the aligned word the store touches, moves the register bytes into those lanes, and presents one aligned write (address, data, byte enables) to a synchronous memory port with a valid/ready handshake.

Left stores fill the word from the register's most significant byte outward. Right stores start from the least significant byte. Which end of the aligned word each store fills depends on the endianness. The lane offset `a` is the address bits below the word size. Byte address `base + k` lives in data lane `k`, which is `mem_wdata[8k+7:8k]`. The word width is a parameter: 32 bits (4 lanes) or 64 bits (8 lanes).

Top module: `partial_store_merger`

## Requirements
- R1: After reset `mem_valid` is 0 and `req_ready` is 1.
- R2: `mem_addr` equals the request address with its low log2(LANES) bits cleared.
- R3: Left store, big-endian (`req_left`=1, `req_little`=0): lanes `a` through `LANES-1` are enabled, and lane `k` carries register byte `LANES-1-(k-a)`. The register's top byte therefore goes to the addressed byte.
- R4: Left store, little-endian (`req_left`=1, `req_little`=1): lanes 0 through `a` are enabled, and lane `k` carries register byte `LANES-1-a+k`.
- R5: Right store, big-endian (`req_left`=0, `req_little`=0): lanes 0 through `a` are enabled, and lane `k` carries register byte `a-k`. The register's bottom byte therefore goes to the addressed byte.
- R6: Right store, little-endian (`req_left`=0, `req_little`=1): lanes `a` through `LANES-1` are enabled, and lane `k` carries register byte `k-a`.
- R7: Every lane whose enable bit is 0 carries 0x00 in `mem_wdata`.
- R8: While `mem_valid`=1 and `mem_ready`=0, `mem_valid`, `mem_addr`, `mem_wdata` and `mem_be` hold their values.
- R9: While a write is pending, `req_ready` is 0 and `req_valid` is ignored. No second request is captured.
- R10: An accepted request (`req_valid` and `req_ready` high at a clock edge) appears on the memory port at that edge. `mem_valid` falls at the edge where `mem_ready` is seen high.
- R11: With `DATA_W`=64 the same lane rules apply over 8 lanes, using address bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | DATA_W | Register value to store |
| req_left | input | 1 | 1 = left-part store, 0 = right-part store |
| req_little | input | 1 | 1 = little-endian, 0 = big-endian |
| mem_valid | output | 1 | Aligned write pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Aligned word address |
| mem_wdata | output | DATA_W | Lane-positioned write data |
| mem_be | output | DATA_W/8 | Byte enables, bit k for lane k |

## Verification
The bench covers all four side/endianness combinations at offset 0, at the last lane and at a middle offset. Those are the points where an off-by-one in the fill range enables one lane too many or one too few, or where a swapped source index reverses the bytes. It checks that unused lanes are zero, which catches a design that leaks register bytes into disabled lanes. It holds `mem_ready` low while a second request is offered. A design that reloads while busy would change the pending write or issue an extra one. The 64-bit instance repeats the mapping checks so that a design hard-wired to two offset bits misplaces bytes there.

// File: rtl/psm_pkg.sv
package psm_pkg;
   // Which end of the aligned word a partial store fills.
   typedef enum logic {
      FILL_LOW  = 1'b0,
      FILL_HIGH = 1'b1
   } fill_dir_e;

   // Left big-endian and right little-endian fill upward from the offset.
   function automatic fill_dir_e pick_dir(input logic left, input logic little);
      return (left ^ little) ? FILL_HIGH : FILL_LOW;
   endfunction
endpackage

// File: rtl/psm_lane_mapper.sv
module psm_lane_mapper
   import psm_pkg::*;
#(
   parameter int LANES = 4,
   localparam int IDX_W = $clog2(LANES),
   localparam int DW    = LANES * 8
) (
   input  logic [IDX_W-1:0] offs,
   input  logic             left,
   input  fill_dir_e        dir,
   input  logic [DW-1:0]    src_data,
   output logic [LANES-1:0] lane_en,
   output logic [DW-1:0]    lane_data
);
   localparam logic [IDX_W-1:0] LMAX = IDX_W'(LANES - 1);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [IDX_W-1:0] KV = IDX_W'(k);
      logic             en;
      logic [IDX_W-1:0] sel;
      always_comb begin
         if (dir == FILL_HIGH) begin
            en  = (KV >= offs);
            sel = left ? (LMAX - (KV - offs)) : (KV - offs);
         end else begin
            en  = (KV <= offs);
            sel = left ? (LMAX - offs + KV) : (offs - KV);
         end
      end
      assign lane_en[k]          = en;
      assign lane_data[k*8 +: 8] = en ? src_data[sel*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/psm_hold_reg.sv
module psm_hold_reg #(
   parameter int ADDR_W = 32,
   parameter int DW     = 32,
   localparam int LANES = DW / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              drain,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic [DW-1:0]     d_data,
   input  logic [LANES-1:0]  d_be,
   output logic              pend,
   output logic [ADDR_W-1:0] q_addr,
   output logic [DW-1:0]     q_data,
   output logic [LANES-1:0]  q_be
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         q_addr <= '0;
         q_data <= '0;
         q_be   <= '0;
      end else if (load) begin
         pend   <= 1'b1;
         q_addr <= d_addr;
         q_data <= d_data;
         q_be   <= d_be;
      end else if (drain) begin
         pend   <= 1'b0;
      end
   end
endmodule

// File: rtl/partial_store_merger.sv
module partial_store_merger
   import psm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int IDX_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_left,
   input  logic              req_little,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [LANES-1:0]  mem_be
);
   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
      $error("partial_store_merger: DATA_W must be 32 or 64");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("partial_store_merger: ADDR_W too small");
   end

   logic [IDX_W-1:0]  offs;
   logic [ADDR_W-1:0] base_addr;
   logic [LANES-1:0]  m_be;
   logic [DATA_W-1:0] m_data;
   logic              pend;
   logic              take;

   assign offs      = req_addr[IDX_W-1:0];
   assign base_addr = {req_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
   assign req_ready = !pend;
   assign take      = req_valid && !pend;

   psm_lane_mapper #(.LANES(LANES)) map_i (
      .offs      (offs),
      .left      (req_left),
      .dir       (pick_dir(req_left, req_little)),
      .src_data  (req_data),
      .lane_en   (m_be),
      .lane_data (m_data)
   );

   psm_hold_reg #(.ADDR_W(ADDR_W), .DW(DATA_W)) hold_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (take),
      .drain  (mem_ready),
      .d_addr (base_addr),
      .d_data (m_data),
      .d_be   (m_be),
      .pend   (pend),
      .q_addr (mem_addr),
      .q_data (mem_wdata),
      .q_be   (mem_be)
   );

   assign mem_valid = pend;
endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int IDX_W = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_left,
   input logic              req_little,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [LANES-1:0]  mem_be
);
   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                  && $stable(mem_wdata) && $stable(mem_be));
   // R9
   busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> !req_ready);
   // R10
   accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> mem_valid);
   // R10
   drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready |=> !mem_valid);
   // R2
   aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_addr[IDX_W-1:0] == '0);
   // R3
   left_be_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_left && !req_little |=> mem_be[LANES-1]);
   // R5
   right_be_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_left && !req_little |=> mem_be[0]);
   // R3
   nonempty_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_be != '0);
endmodule

bind partial_store_merger psm_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .req_left   (req_left),
   .req_little (req_little),
   .mem_valid  (mem_valid),
   .mem_ready  (mem_ready),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_be     (mem_be)
);

// File: tb/partial_store_merger_tb_top.sv
module partial_store_merger_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int n_run = 0;
   int n_fail = 0;

   // 32-bit instance
   logic        a_rv = 0, a_rl = 0, a_le = 0, a_mr = 0;
   logic [31:0] a_addr = '0, a_data = '0;
   logic        a_rr, a_mv;
   logic [31:0] a_maddr, a_wd;
   logic [3:0]  a_be;

   partial_store_merger #(.DATA_W(32), .ADDR_W(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(a_rv), .req_ready(a_rr),
      .req_addr(a_addr), .req_data(a_data), .req_left(a_rl), .req_little(a_le),
      .mem_valid(a_mv), .mem_ready(a_mr), .mem_addr(a_maddr),
      .mem_wdata(a_wd), .mem_be(a_be));

   // 64-bit instance
   logic        b_rv = 0, b_rl = 0, b_le = 0, b_mr = 0;
   logic [31:0] b_addr = '0;
   logic [63:0] b_data = '0;
   logic        b_rr, b_mv;
   logic [31:0] b_maddr;
   logic [63:0] b_wd;
   logic [7:0]  b_be;

   partial_store_merger #(.DATA_W(64), .ADDR_W(32)) dut64_i (
      .clk(clk), .rst_n(rst_n), .req_valid(b_rv), .req_ready(b_rr),
      .req_addr(b_addr), .req_data(b_data), .req_left(b_rl), .req_little(b_le),
      .mem_valid(b_mv), .mem_ready(b_mr), .mem_addr(b_maddr),
      .mem_wdata(b_wd), .mem_be(b_be));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected lane image from the requirement formulas (n lanes, offset a).
   function automatic void model(input int n, input logic left, input logic little,
                                 input int a, input logic [63:0] d,
                                 output logic [63:0] wd, output logic [7:0] be);
      wd = '0; be = '0;
      for (int k = 0; k < n; k++) begin
         int s; bit on;
         if (left && !little)      begin on = (k >= a); s = n - 1 - (k - a); end
         else if (left && little)  begin on = (k <= a); s = n - 1 - a + k;   end
         else if (!left && !little) begin on = (k <= a); s = a - k;          end
         else                      begin on = (k >= a); s = k - a;           end
         if (on) begin
            be[k] = 1'b1;
            wd[k*8 +: 8] = d[s*8 +: 8];
         end
      end
   endfunction

   task automatic store32(input string req, input logic left, input logic little,
                          input logic [31:0] addr, input logic [31:0] d);
      logic [63:0] ewd; logic [7:0] ebe;
      model(4, left, little, int'(addr[1:0]), {32'h0, d}, ewd, ebe);
      @(negedge clk);
      a_rv = 1; a_rl = left; a_le = little; a_addr = addr; a_data = d;
      @(negedge clk);
      a_rv = 0;
      check({req, " valid"}, a_mv, 1);
      check({req, " addr"}, a_maddr, {addr[31:2], 2'b00});
      check({req, " be"}, a_be, ebe[3:0]);
      check({req, " data"}, a_wd, ewd[31:0]);
      a_mr = 1;
      @(negedge clk);
      a_mr = 0;
      check("R10 drain", a_mv, 0);
   endtask

   task automatic store64(input string req, input logic left, input logic little,
                          input logic [31:0] addr, input logic [63:0] d);
      logic [63:0] ewd; logic [7:0] ebe;
      model(8, left, little, int'(addr[2:0]), d, ewd, ebe);
      @(negedge clk);
      b_rv = 1; b_rl = left; b_le = little; b_addr = addr; b_data = d;
      @(negedge clk);
      b_rv = 0;
      check({req, " addr"}, b_maddr, {addr[31:3], 3'b000});
      check({req, " be"}, b_be, ebe);
      check({req, " data"}, b_wd, ewd);
      b_mr = 1;
      @(negedge clk);
      b_mr = 0;
      check("R11 drain", b_mv, 0);
   endtask

   task automatic t_reset();
      check("R1 mem_valid", a_mv, 0);
      check("R1 req_ready", a_rr, 1);
      check("R1 mem_valid64", b_mv, 0);
   endtask

   task automatic t_fixed_vectors();
      // Hand-worked values at offset 1, register 0xAABBCCDD.
      store32("R3 left BE", 1, 0, 32'h101, 32'hAABBCCDD);
      check("R3 fixed data", a_wd, 32'hCCBBAA00);
      store32("R4 left LE", 1, 1, 32'h101, 32'hAABBCCDD);
      check("R4 fixed data", a_wd, 32'h0000AABB);
      store32("R5 right BE", 0, 0, 32'h101, 32'hAABBCCDD);
      check("R5 fixed data", a_wd, 32'h0000DDCC);
      store32("R6 right LE", 0, 1, 32'h101, 32'hAABBCCDD);
      check("R6 fixed data", a_wd, 32'hBBCCDD00);
   endtask

   task automatic t_sweep32();
      for (int a = 0; a < 4; a++) begin
         store32("R3 left BE", 1, 0, 32'h2000 + a, 32'h11223344);
         store32("R4 left LE", 1, 1, 32'h2000 + a, 32'h55667788);
         store32("R5 right BE", 0, 0, 32'hF00C + a, 32'h99AABBCC);
         store32("R6 right LE", 0, 1, 32'hF00C + a, 32'hDDEEFF01);
      end
      // R7: corner offsets leave one lane only
      store32("R7 single lane", 1, 0, 32'h3003, 32'hA5000000);
      check("R7 zero lanes", a_wd[23:0], 24'h0);
      check("R2 aligned", a_maddr, 32'h3000);
   endtask

   task automatic t_hold_busy();
      @(negedge clk);
      a_rv = 1; a_rl = 1; a_le = 0; a_addr = 32'h4002; a_data = 32'hCAFEBABE;
      @(negedge clk);
      // second request offered while busy, memory not ready
      a_addr = 32'h5000; a_data = 32'h12345678; a_rl = 0;
      check("R9 ready low", a_rr, 0);
      repeat (3) @(negedge clk);
      check("R8 valid held", a_mv, 1);
      check("R8 addr held", a_maddr, 32'h4000);
      check("R8 be held", a_be, 4'b1100);
      check("R8 data held", a_wd, 32'hFECA0000);
      a_rv = 0;
      a_mr = 1;
      @(negedge clk);
      a_mr = 0;
      check("R10 cleared", a_mv, 0);
      repeat (2) @(negedge clk);
      check("R9 no extra write", a_mv, 0);
   endtask

   task automatic t_sweep64();
      for (int a = 0; a < 8; a++) begin
         store64("R11 left BE", 1, 0, 32'h8000 + a, 64'h0102030405060708);
         store64("R11 left LE", 1, 1, 32'h8000 + a, 64'h1112131415161718);
         store64("R11 right BE", 0, 0, 32'h8000 + a, 64'h2122232425262728);
         store64("R11 right LE", 0, 1, 32'h8000 + a, 64'h3132333435363738);
      end
      store64("R11 fixed", 1, 0, 32'h8005, 64'h0102030405060708);
      check("R11 fixed data", b_wd, 64'h0302010000000000);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_fixed_vectors();
      t_sweep32();
      t_hold_busy();
      t_sweep64();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule